// File: doc/BRIEF.md
# Bus Clock Ratio Strobe Generator

This block runs on the fast core clock and derives two single-cycle enable strobes from it. One marks the active edges of the high-speed bus domain. The other marks the active edges of the peripheral bus domain. It also drives a static select that tells the USB clock path whether to halve its input. Downstream logic qualifies its registers with these strobes instead of using separately gated clocks.

Two control words set the ratios. Software writes them over a small synchronous register port:

- The main word holds a two-bit bus ratio field, a peripheral halving bit and a USB halving bit.
- The auxiliary word holds two override bits. One doubles the divide-by-4 setting to 8, and the other doubles the divide-by-3 setting to 6.

The peripheral strobe is always derived from the bus strobe, never directly from the core clock.

Ratio changes are staged. A newly written setting waits in the register until the next cycle where both strobes fire together. On that cycle it is loaded into the counters, so every strobe interval is a whole period of either the old setting or the new one.

Top module: `bus_clk_ratio`

## Requirements
- R1: After reset both control words read zero, usb_half_o is 0, and hclk_en_o and pclk_en_o are both high on every cycle (ratio 1:1:1).
- R2: With both overrides clear, main word bits [2:1] set the bus period in core cycles: 00 gives 1, 01 gives 2, 10 gives 4 and 11 gives 3.
- R3: Auxiliary word bit 9 changes the field-10 period from 4 to 8. It has no effect on any other field value.
- R4: Auxiliary word bit 8 changes the field-11 period from 3 to 6. It has no effect on any other field value.
- R5: Main word bit 0 sets the peripheral period. A value of 0 gives the bus period, and a value of 1 gives twice the bus period. pclk_en_o is only ever high on a cycle where hclk_en_o is high.
- R6: usb_half_o equals main word bit 3 from the cycle after the write.
- R7: Writing 5 to the main word with both overrides clear gives a core:bus:peripheral period ratio of 1:4:8.
- R8: hclk_en_o is high for one cycle and then low for N-1 cycles, where N is the bus period.
- R9: A new setting is first used on a cycle where both strobes are high. Every strobe interval during a change equals either the old period or the new period.
- R10: Address 0 selects the main word (bits 3:0) and address 1 the auxiliary word (bits 9:8). All other bits read as zero and ignore writes. rdata_o shows the word selected by addr_i in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write enable |
| addr_i | input | 1 | Word select: 0 main, 1 auxiliary |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data of the selected word |
| hclk_en_o | output | 1 | Bus domain enable strobe |
| pclk_en_o | output | 1 | Peripheral domain enable strobe |
| usb_half_o | output | 1 | USB clock halving select |

## Verification
The bench applies all four ratio field values, with each override both set and clear, so the periods 1, 2, 3, 4, 6 and 8 are all measured. Seeing 4 and 8 as separate results confirms that each override applies only to its own field. Each bus setting is paired with both peripheral settings, which distinguishes equal peripheral and bus periods from a doubled peripheral period.

Ratio changes are written at two points. One write lands just after a peripheral strobe, where the bus strobe must keep the old period for two more intervals. Other writes land mid-period, and all intervals are watched for any value other than the old or new period. Read-back after all-ones writes separates stored bits from reserved ones.

// File: rtl/bus_clk_ratio_pkg.sv
`timescale 1ns/1ps
package bus_clk_ratio_pkg;
  localparam int MAX_DIV = 8;
  localparam int CNT_W   = $clog2(MAX_DIV);
  // bit positions decoded by software
  localparam int B_PHALF = 0;
  localparam int B_HSEL  = 1;
  localparam int B_USB   = 3;
  localparam int B_OV6   = 8;
  localparam int B_OV8   = 9;

  typedef struct packed {
    logic [1:0] hsel;
    logic       phalf;
    logic       ov8;
    logic       ov6;
  } ratio_sel_t;

  typedef logic [CNT_W-1:0] reload_t;
endpackage

// File: rtl/ratio_decode.sv
`timescale 1ns/1ps
module ratio_decode
  import bus_clk_ratio_pkg::*;
(
  input  ratio_sel_t sel_i,
  output reload_t    reload_o
);
  // reload value is period minus one
  always_comb begin
    unique case (sel_i.hsel)
      2'b00:   reload_o = reload_t'(0);
      2'b01:   reload_o = reload_t'(1);
      2'b10:   reload_o = sel_i.ov8 ? reload_t'(7) : reload_t'(3);
      default: reload_o = sel_i.ov6 ? reload_t'(5) : reload_t'(2);
    endcase
  end
endmodule

// File: rtl/ratio_regs.sv
`timescale 1ns/1ps
module ratio_regs
  import bus_clk_ratio_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output ratio_sel_t        sel_o,
  output logic              usb_half_o,
  output logic [DATA_W-1:0] rdata_o
);
  ratio_sel_t sel_q;
  logic       usb_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q <= '0;
      usb_q <= 1'b0;
    end else if (wr_en_i) begin
      if (!addr_i) begin
        sel_q.phalf <= wdata_i[B_PHALF];
        sel_q.hsel  <= wdata_i[B_HSEL+1:B_HSEL];
        usb_q       <= wdata_i[B_USB];
      end else begin
        sel_q.ov6 <= wdata_i[B_OV6];
        sel_q.ov8 <= wdata_i[B_OV8];
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    if (!addr_i) begin
      rdata_o[B_PHALF]           = sel_q.phalf;
      rdata_o[B_HSEL+1:B_HSEL]   = sel_q.hsel;
      rdata_o[B_USB]             = usb_q;
    end else begin
      rdata_o[B_OV6] = sel_q.ov6;
      rdata_o[B_OV8] = sel_q.ov8;
    end
  end

  assign sel_o      = sel_q;
  assign usb_half_o = usb_q;

  p_usb_follow_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(wr_en_i && !addr_i) |-> (usb_half_o == $past(wdata_i[B_USB])));
  p_rsvd_main_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !addr_i |-> (rdata_o[DATA_W-1:B_USB+1] == '0));
  p_rsvd_aux_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_i |-> (rdata_o[B_OV6-1:0] == '0));
endmodule

// File: rtl/strobe_gen.sv
`timescale 1ns/1ps
module strobe_gen
  import bus_clk_ratio_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  ratio_sel_t pend_i,
  output logic       hclk_en_o,
  output logic       pclk_en_o
);
  ratio_sel_t act_q;
  reload_t    cnt_q;
  logic       pph_q;
  reload_t    act_reload, pend_reload;
  logic       boundary;

  ratio_decode u_dec_act  (.sel_i(act_q),  .reload_o(act_reload));
  ratio_decode u_dec_pend (.sel_i(pend_i), .reload_o(pend_reload));

  assign hclk_en_o = (cnt_q == '0);
  assign pclk_en_o = hclk_en_o && !pph_q;
  assign boundary  = pclk_en_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= '0;
      cnt_q <= '0;
      pph_q <= 1'b0;
    end else if (boundary) begin
      // switch-over point: both strobes fire together
      act_q <= pend_i;
      cnt_q <= pend_reload;
      pph_q <= pend_i.phalf;
    end else if (hclk_en_o) begin
      cnt_q <= act_reload;
      pph_q <= 1'b0;
    end else begin
      cnt_q <= cnt_q - reload_t'(1);
    end
  end

  p_pclk_in_hclk_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pclk_en_o |-> hclk_en_o);
  p_switch_at_boundary_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_q != $past(act_q)) |-> $past(pclk_en_o));
  p_hclk_gap_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hclk_en_o && !pclk_en_o && act_reload != '0) |=> !hclk_en_o);
  p_phalf_skip_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pclk_en_o && pend_i.phalf) |=> !pclk_en_o);
endmodule

// File: rtl/bus_clk_ratio.sv
`timescale 1ns/1ps
module bus_clk_ratio
  import bus_clk_ratio_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              hclk_en_o,
  output logic              pclk_en_o,
  output logic              usb_half_o
);
  ratio_sel_t pend_sel;

  ratio_regs #(.DATA_W(DATA_W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .sel_o      (pend_sel),
    .usb_half_o (usb_half_o),
    .rdata_o    (rdata_o)
  );

  strobe_gen u_strobe (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .pend_i    (pend_sel),
    .hclk_en_o (hclk_en_o),
    .pclk_en_o (pclk_en_o)
  );

  p_reset_ratio_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (hclk_en_o && pclk_en_o));
endmodule

// File: tb/sim_bus_clk_ratio.sv
`timescale 1ns/1ps
module sim_bus_clk_ratio;
  localparam int DW = 16;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic addr = 1'b0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic hclk_en, pclk_en, usb_half;

  int n_chk = 0, n_fail = 0;
  int cyc = 0, h_last = 0, p_last = 0, h_int = 0, p_int = 0;
  int h_seen = 0, p_seen = 0;
  bit win_on = 0;
  int win_ha, win_hb, win_pa, win_pb, win_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  bus_clk_ratio #(.DATA_W(DW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .hclk_en_o(hclk_en),
    .pclk_en_o(pclk_en), .usb_half_o(usb_half)
  );

  always @(negedge clk) if (rst_n) begin
    cyc++;
    if (pclk_en && !hclk_en) begin
      n_chk++; n_fail++;
      $display("FAIL R5: pclk strobe without hclk strobe act=1 exp=0 cyc=%0d", cyc);
    end
    if (hclk_en) begin
      h_int = cyc - h_last; h_last = cyc; h_seen++;
      if (win_on && h_int != win_ha && h_int != win_hb) win_bad++;
    end
    if (pclk_en) begin
      p_int = cyc - p_last; p_last = cyc; p_seen++;
      if (win_on && p_int != win_pa && p_int != win_pb) win_bad++;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [DW-1:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0; wdata = '0;
  endtask

  task automatic wait_h(input int n);
    int s = h_seen;
    while (h_seen < s + n) @(posedge clk);
  endtask

  task automatic wait_p(input int n);
    int s = p_seen;
    while (p_seen < s + n) @(posedge clk);
  endtask

  // main word: [2:1] hsel, [0] phalf; aux: [9] ov8, [8] ov6
  task automatic set_cfg(input logic [1:0] hs, input bit ph, input bit o8, input bit o6);
    wr(1'b1, DW'((int'(o8) << 9) | (int'(o6) << 8)));
    wr(1'b0, DW'((int'(hs) << 1) | int'(ph)));
    repeat (40) @(negedge clk);
  endtask

  task automatic t_ratio(input logic [1:0] hs, input bit ph, input bit o8, input bit o6,
                         input int en, input string req);
    set_cfg(hs, ph, o8, o6);
    wait_h(2);
    chk(h_int == en, {req, " hclk period"}, h_int, en);
    wait_p(2);
    chk(p_int == en * (ph ? 2 : 1), {req, " R5 pclk period"}, p_int, en * (ph ? 2 : 1));
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(hclk_en && pclk_en, "R1 strobes high", int'(hclk_en & pclk_en), 1);
    @(negedge clk);
    chk(hclk_en && pclk_en, "R1 strobes high next cycle", int'(hclk_en & pclk_en), 1);
    chk(usb_half == 1'b0, "R1 usb_half", int'(usb_half), 0);
    addr = 1'b0; #0.1;
    chk(rdata == '0, "R1 main word", int'(rdata), 0);
    addr = 1'b1; #0.1;
    chk(rdata == '0, "R1 aux word", int'(rdata), 0);
  endtask

  task automatic t_regs();
    wr(1'b0, '1);
    addr = 1'b0; #0.1;
    chk(rdata == DW'(16'h000F), "R10 main readback", int'(rdata), 'hF);
    chk(usb_half == 1'b1, "R6 usb_half set", int'(usb_half), 1);
    wr(1'b1, '1);
    addr = 1'b1; #0.1;
    chk(rdata == DW'(16'h0300), "R10 aux readback", int'(rdata), 'h300);
    addr = 1'b0; #0.1;
    chk(rdata == DW'(16'h000F), "R10 main unchanged by aux write", int'(rdata), 'hF);
    wr(1'b0, DW'(16'h0007));
    chk(usb_half == 1'b0, "R6 usb_half cleared", int'(usb_half), 0);
  endtask

  task automatic t_switch_late();
    // old 1:4:8, write right after a pclk strobe, new period 2
    set_cfg(2'b10, 1'b1, 1'b0, 1'b0);
    wait_p(1);
    @(negedge clk); wr_en = 1'b1; addr = 1'b0; wdata = DW'(16'h0002);
    @(negedge clk); wr_en = 1'b0;
    wait_h(1);
    chk(h_int == 4, "R9 old period kept (1)", h_int, 4);
    wait_h(1);
    chk(h_int == 4, "R9 old period kept until boundary (2)", h_int, 4);
    wait_h(1);
    chk(h_int == 2, "R9 new period after boundary", h_int, 2);
  endtask

  task automatic t_switch_win(input logic [1:0] h0, input bit p0, input bit o80, int n0,
                              input logic [1:0] h1, input bit p1, input bit o81, int n1);
    set_cfg(h0, p0, o80, 1'b0);
    win_ha = n0; win_pa = n0 * (p0 ? 2 : 1);
    win_hb = n1; win_pb = n1 * (p1 ? 2 : 1);
    win_bad = 0; win_on = 1;
    repeat (3) @(negedge clk);
    wr(1'b1, DW'(int'(o81) << 9));
    wr(1'b0, DW'((int'(h1) << 1) | int'(p1)));
    repeat (60) @(negedge clk);
    win_on = 0;
    chk(win_bad == 0, "R9 intervals only old or new", win_bad, 0);
    chk(h_int == n1, "R9 settled new hclk period", h_int, n1);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: act=timeout exp=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_regs();
    t_ratio(2'b00, 1'b0, 1'b0, 1'b0, 1, "R2 div1");
    t_ratio(2'b00, 1'b1, 1'b1, 1'b1, 1, "R2 div1 overrides ignored R3 R4");
    t_ratio(2'b01, 1'b1, 1'b0, 1'b0, 2, "R2 div2");
    t_ratio(2'b01, 1'b0, 1'b1, 1'b1, 2, "R2 div2 overrides ignored R3 R4");
    t_ratio(2'b10, 1'b1, 1'b0, 1'b0, 4, "R7 div4 value 5");
    t_ratio(2'b10, 1'b0, 1'b0, 1'b1, 4, "R2 div4 ov6 ignored R4");
    t_ratio(2'b10, 1'b0, 1'b1, 1'b0, 8, "R3 div8");
    t_ratio(2'b10, 1'b1, 1'b1, 1'b0, 8, "R3 div8 halved pclk R8");
    t_ratio(2'b11, 1'b0, 1'b0, 1'b0, 3, "R2 div3");
    t_ratio(2'b11, 1'b1, 1'b1, 1'b0, 3, "R2 div3 ov8 ignored R3");
    t_ratio(2'b11, 1'b0, 1'b0, 1'b1, 6, "R4 div6");
    t_ratio(2'b11, 1'b1, 1'b0, 1'b1, 6, "R4 div6 halved pclk");
    t_switch_late();
    t_switch_win(2'b10, 1'b1, 1'b1, 8, 2'b00, 1'b1, 1'b0, 1);
    t_switch_win(2'b01, 1'b0, 1'b0, 2, 2'b11, 1'b1, 1'b0, 3);
    t_switch_win(2'b00, 1'b0, 1'b0, 1, 2'b10, 1'b1, 1'b1, 8);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule